// File: doc/BRIEF.md
# Upper-memory shadow and SMRAM router

This block decides, for every CPU access into the legacy one-megabyte space, whether the cycle is served by on-board DRAM or sent out to the expansion bus. Below A0000h everything belongs to DRAM. The option-ROM area C0000h–DFFFFh and the system-ROM area E0000h–FFFFFh are divided into shadowable segments. Each segment has its own enable. Two global bits choose whether reads and writes to an enabled segment hit the DRAM copy.

On top of the shadow map sits a system-management RAM window. Its placement is chosen from three layouts. One layout moves its DRAM target to a lower address. Whether the window reaches DRAM depends on the SMM-active flag and an outside-SMM visibility bit. The router also returns the DRAM address to use, which differs from the CPU address only for the relocated layout. All decisions are registered. A separate one-cycle pulse marks every clock in which a routing-relevant configuration bit has changed, so that downstream caches know when to re-evaluate.

Top module: `umem_route`

## Requirements
- R1: For addresses C0000h–DFFFFh, segment i (16 KB, starting at C0000h + i×4000h, i = 0..7) is enabled by bit i of `shadow_lo`.
- R2: For addresses E0000h–FFFFFh, segment i (32 KB, starting at E0000h + i×8000h, i = 0..3) is enabled by bit i of `shadow_ctl`.
- R3: `acc_kind` encodes 00 = read, 01 = write, 10 = code fetch, 11 = read. In an enabled segment, a write goes to DRAM when `shadow_ctl[5]` is 1, and any other kind goes to DRAM when `shadow_ctl[4]` is 1. Otherwise the access goes to the bus.
- R4: A disabled shadow segment sends every access kind to the bus. An A0000h–BFFFFh access that is not inside an active SMRAM window also goes to the bus.
- R5: `smm_ctl[5:4]` = 00 gives no SMRAM window. A value of 01 gives a window over A0000h–BFFFFh with DRAM address equal to the CPU address.
- R6: `smm_ctl[5:4]` = 10 gives a window over E0000h–EFFFFh, but only while `shadow_ctl[1:0]` = 00. Otherwise those addresses follow the shadow rules.
- R7: `smm_ctl[5:4]` = 11 gives a window over A8000h–AFFFFh. The DRAM address is 68000h plus the offset when `smi_stat[7:6]` = 10, and 38000h plus the offset for any other value.
- R8: An access inside an active window sets `is_smram`. It goes to DRAM when `in_smm` is 1 or `smm_ctl[3]` is 1, and to the bus otherwise.
- R9: With `smm_ctl[5:4]` = 01 and `smm_ctl[0]` = 1, a code fetch inside the window goes to DRAM even outside SMM.
- R10: An address below A0000h goes to DRAM with `is_smram` = 0 and an unchanged DRAM address. Outside layout 11, the DRAM address always equals the CPU address.
- R11: All outputs appear one clock after their inputs are sampled. During synchronous active-low reset, all outputs are 0.
- R12: `cfg_changed` is 1 for the cycle after an edge at which any of these bits differs from its value at the previous edge: `shadow_lo`, `shadow_ctl[5:0]`, `smm_ctl[5:3]`, `smm_ctl[0]`, `smi_stat[7:6]`. Changes confined to other bits give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 20 | CPU physical address |
| acc_kind | input | 2 | Access kind: read, write, fetch |
| in_smm | input | 1 | CPU is in system-management mode |
| shadow_lo | input | 8 | Segment enables for C0000h–DFFFFh |
| shadow_ctl | input | 8 | High segment enables and read/write shadow bits |
| smm_ctl | input | 8 | SMRAM layout, visibility and fetch override |
| smi_stat | input | 8 | Status bits 7:6 choose the relocation base |
| to_dram | output | 1 | Access is served by DRAM (else bus) |
| is_smram | output | 1 | Access falls in the active SMRAM window |
| dram_addr | output | 20 | DRAM address for the access |
| cfg_changed | output | 1 | One-cycle pulse after a relevant configuration change |

## Verification
The bench uses the default relocation bases, 68000h and 38000h. This keeps the layout-11 remap results on known addresses that can be compared directly against the offset arithmetic. Random address draws are skewed toward A0000h–FFFFFh, so every segment boundary, every window and every layout and access-kind pairing is reached many times. The draws also include registers whose irrelevant bits toggle by themselves, which exercises the change detector's masking.

// File: rtl/umem_route.sv
module umem_route #(
  parameter logic [19:0] RELOC_HI_BASE = 20'h68000,
  parameter logic [19:0] RELOC_LO_BASE = 20'h38000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] addr,
  input  logic [1:0]  acc_kind,
  input  logic        in_smm,
  input  logic [7:0]  shadow_lo,
  input  logic [7:0]  shadow_ctl,
  input  logic [7:0]  smm_ctl,
  input  logic [7:0]  smi_stat,
  output logic        to_dram,
  output logic        is_smram,
  output logic [19:0] dram_addr,
  output logic        cfg_changed
);
  localparam logic [1:0] KIND_WR = 2'b01;
  localparam logic [1:0] KIND_IF = 2'b10;
  localparam int CFG_W = 20;

  wire [1:0] layout = smm_ctl[5:4];
  wire in_ab = addr[19:17] == 3'b101;
  wire in_cd = addr[19:17] == 3'b110;
  wire in_ef = addr[19:17] == 3'b111;
  wire upper = in_ab | in_cd | in_ef;

  wire seg_on = (in_cd & shadow_lo[addr[16:14]]) | (in_ef & shadow_ctl[addr[16:15]]);
  wire seg_dram = seg_on & ((acc_kind == KIND_WR) ? shadow_ctl[5] : shadow_ctl[4]);

  wire win_a = (layout == 2'b01) & in_ab;
  wire win_e = (layout == 2'b10) & (addr[19:16] == 4'hE) & (shadow_ctl[1:0] == 2'b00);
  wire win_r = (layout == 2'b11) & (addr[19:15] == 5'b10101);
  wire in_win = win_a | win_e | win_r;
  wire win_open = in_smm | smm_ctl[3] | (win_a & smm_ctl[0] & (acc_kind == KIND_IF));

  wire [19:0] reloc_base = (smi_stat[7:6] == 2'b10) ? RELOC_HI_BASE : RELOC_LO_BASE;

  logic        route_d;
  logic [19:0] addr_d;
  always_comb begin
    if (!upper)       route_d = 1'b1;
    else if (in_win)  route_d = win_open;
    else if (in_ab)   route_d = 1'b0;
    else              route_d = seg_dram;
    addr_d = win_r ? {reloc_base[19:15], addr[14:0]} : addr;
  end

  wire [CFG_W-1:0] cfg_now = {shadow_lo, shadow_ctl[5:0], smm_ctl[5:3], smm_ctl[0], smi_stat[7:6]};
  logic [CFG_W-1:0] cfg_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_dram     <= 1'b0;
      is_smram    <= 1'b0;
      dram_addr   <= '0;
      cfg_changed <= 1'b0;
      cfg_prev    <= cfg_now;
    end else begin
      to_dram     <= route_d;
      is_smram    <= in_win & upper;
      dram_addr   <= addr_d;
      cfg_changed <= cfg_now != cfg_prev;
      cfg_prev    <= cfg_now;
    end
  end
endmodule

// File: rtl/umem_route_chk.sv
module umem_route_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [19:0] addr,
  input logic [1:0]  acc_kind,
  input logic        in_smm,
  input logic [7:0]  shadow_lo,
  input logic [7:0]  shadow_ctl,
  input logic [7:0]  smm_ctl,
  input logic [7:0]  smi_stat,
  input logic        to_dram,
  input logic        is_smram,
  input logic [19:0] dram_addr,
  input logic        cfg_changed
);
  a_r10_low_to_dram: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < 20'hA0000) |=> (to_dram && !is_smram));

  a_r4_disabled_seg_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[19:17] == 3'b110 && !shadow_lo[addr[16:14]]) |=> !to_dram);

  a_r5_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_ctl[5:4] == 2'b00) |=> !is_smram);

  a_r9_fetch_override: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_ctl[5:4] == 2'b01 && smm_ctl[0] && acc_kind == 2'b10 && addr[19:17] == 3'b101)
      |=> (to_dram && is_smram));

  a_r12_quiet_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(shadow_lo) && $stable(shadow_ctl[5:0]) && $stable(smm_ctl[5:3]) &&
     $stable(smm_ctl[0]) && $stable(smi_stat[7:6])) |=> !cfg_changed);
endmodule

bind umem_route umem_route_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .acc_kind(acc_kind), .in_smm(in_smm),
  .shadow_lo(shadow_lo), .shadow_ctl(shadow_ctl), .smm_ctl(smm_ctl), .smi_stat(smi_stat),
  .to_dram(to_dram), .is_smram(is_smram), .dram_addr(dram_addr), .cfg_changed(cfg_changed)
);

// File: tb/sim_umem_route.sv
module sim_umem_route;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        in_smm = 1'b0;
  logic [7:0]  shadow_lo = '0, shadow_ctl = '0, smm_ctl = '0, smi_stat = '0;
  logic        to_dram, is_smram, cfg_changed;
  logic [19:0] dram_addr;
  int total = 0, fails = 0;
  logic [31:0] prev_rel = '0;

  always #5 clk = ~clk;

  umem_route u0 (.*);

  function automatic logic [21:0] model(input logic [19:0] a, input logic [1:0] k,
      input logic smm, input logic [7:0] lo, input logic [7:0] ctl,
      input logic [7:0] sc, input logic [7:0] ss);
    logic smr, dr, en;
    logic [19:0] da;
    logic [1:0] lay;
    if (a < 20'hA0000) return {1'b1, 1'b0, a};
    lay = sc[5:4];
    smr = 1'b0;
    da = a;
    if (lay == 2'd1 && a < 20'hC0000) smr = 1'b1;
    if (lay == 2'd2 && a >= 20'hE0000 && a < 20'hF0000 && ctl[1:0] == 2'b00) smr = 1'b1;
    if (lay == 2'd3 && a >= 20'hA8000 && a < 20'hB0000) begin
      smr = 1'b1;
      da = ((ss[7:6] == 2'b10) ? 20'h68000 : 20'h38000) + (a - 20'hA8000);
    end
    if (smr) dr = smm || sc[3] || (lay == 2'd1 && sc[0] && k == 2'b10);
    else if (a < 20'hC0000) dr = 1'b0;
    else begin
      if (a < 20'hE0000) en = lo[(a - 20'hC0000) / 20'h4000];
      else en = ctl[(a - 20'hE0000) / 20'h8000];
      dr = en && ((k == 2'b01) ? ctl[5] : ctl[4]);
    end
    return {dr, smr, da};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [19:0] a, input logic [1:0] k, input logic smm,
      input logic [7:0] lo, input logic [7:0] ctl, input logic [7:0] sc, input logic [7:0] ss,
      input string req);
    logic [21:0] e;
    logic [31:0] rel;
    logic ep;
    @(negedge clk);
    addr = a; acc_kind = k; in_smm = smm;
    shadow_lo = lo; shadow_ctl = ctl; smm_ctl = sc; smi_stat = ss;
    e = model(a, k, smm, lo, ctl, sc, ss);
    rel = {lo, ctl & 8'h3F, sc & 8'h39, ss & 8'hC0};
    ep = rel != prev_rel;
    prev_rel = rel;
    @(posedge clk);
    #2;
    check(to_dram === e[21], {req, " route"}, {31'd0, to_dram}, {31'd0, e[21]});
    check(is_smram === e[20], {req, " smram"}, {31'd0, is_smram}, {31'd0, e[20]});
    check(dram_addr === e[19:0], {req, " addr"}, {12'd0, dram_addr}, {12'd0, e[19:0]});
    check(cfg_changed === ep, {req, " R12 pulse"}, {31'd0, cfg_changed}, {31'd0, ep});
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #2;
    check({to_dram, is_smram, dram_addr, cfg_changed} === 23'd0, "R11 reset",
          {9'd0, to_dram, is_smram, dram_addr, cfg_changed}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    step(20'h12345, 2'b00, 0, 8'h00, 8'h00, 8'h00, 8'h00, "R10 low");
    step(20'h9FFFF, 2'b01, 0, 8'h00, 8'h00, 8'h10, 8'h00, "R10 edge");
    step(20'hC8000, 2'b00, 0, 8'h04, 8'h10, 8'h00, 8'h00, "R1 seg2 read");
    step(20'hC4000, 2'b00, 0, 8'h04, 8'h10, 8'h00, 8'h00, "R4 seg1 off");
    step(20'hCBFFF, 2'b01, 0, 8'h04, 8'h10, 8'h00, 8'h00, "R3 write no wbit");
    step(20'hCBFFF, 2'b01, 0, 8'h04, 8'h20, 8'h00, 8'h00, "R3 write wbit");
    step(20'hC8010, 2'b10, 0, 8'h04, 8'h10, 8'h00, 8'h00, "R3 fetch");
    step(20'hF9000, 2'b00, 0, 8'h00, 8'h18, 8'h00, 8'h00, "R2 seg3");
    step(20'hE0000, 2'b00, 0, 8'h00, 8'h18, 8'h00, 8'h00, "R4 hi seg0 off");
    step(20'hB0000, 2'b00, 1, 8'h00, 8'h00, 8'h00, 8'h00, "R5 layout00");
    step(20'hB0000, 2'b00, 1, 8'h00, 8'h00, 8'h10, 8'h00, "R5 layout01");
    step(20'hB0000, 2'b00, 0, 8'h00, 8'h00, 8'h10, 8'h00, "R8 closed");
    step(20'hB0000, 2'b01, 0, 8'h00, 8'h00, 8'h18, 8'h00, "R8 visible");
    step(20'hA1000, 2'b10, 0, 8'h00, 8'h00, 8'h11, 8'h00, "R9 fetch");
    step(20'hA1000, 2'b00, 0, 8'h00, 8'h00, 8'h11, 8'h00, "R9 read");
    step(20'hE4000, 2'b00, 1, 8'h00, 8'h00, 8'h20, 8'h00, "R6 active");
    step(20'hE4000, 2'b00, 1, 8'h00, 8'h01, 8'h20, 8'h00, "R6 blocked");
    step(20'hA9234, 2'b00, 1, 8'h00, 8'h00, 8'h30, 8'h80, "R7 hi base");
    step(20'hA9234, 2'b00, 1, 8'h00, 8'h00, 8'h30, 8'h40, "R7 lo base");
    step(20'hA4000, 2'b00, 1, 8'h00, 8'h00, 8'h30, 8'h40, "R7 outside");
    step(20'hA4000, 2'b00, 1, 8'h00, 8'h00, 8'h30, 8'h40, "R12 hold");
    step(20'hA4000, 2'b00, 1, 8'h00, 8'hC0, 8'hF6, 8'h7F, "R12 masked bits");
    step(20'hA4000, 2'b00, 1, 8'h00, 8'hC0, 8'hF6, 8'hBF, "R12 status bit");

    for (int i = 0; i < 600; i++) begin
      logic [19:0] a;
      logic [7:0] lo, ctl, sc, ss;
      a = $urandom;
      if ($urandom_range(0, 9) != 0) a[19:17] = 3'($urandom_range(5, 7));
      lo = 8'($urandom); ctl = 8'($urandom); sc = 8'($urandom); ss = 8'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        lo = shadow_lo; ctl = shadow_ctl; sc = smm_ctl; ss = smi_stat;
      end
      step(a, 2'($urandom), 1'($urandom), lo, ctl, sc, ss, "R1 R2 R3 R6 R7 R8 random");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule